// File: doc/BRIEF.md
# Bidirectional Universal Bus Register

This block sits between two 18-bit buses, called side A and side B, and moves data both ways. Each direction has its own storage register and its own three controls: a latch enable, a capture clock and a drive enable. While the latch enable is high, data flows straight through. While it is low, the stored word is kept, and a rising edge on the capture clock loads a fresh word. The drive enable for the A-to-B direction is active high. The drive enable for the B-to-A direction is active low.

The model is synchronous. One system clock samples every control, and a rising edge of the sampled capture clock is the capture event. Neither side has a real tri-state pin. Each side gets a data output and a drive flag, and the data output reads zero whenever its flag is low.

Top module: `bidir_bus_reg`

## Requirements
- R1: While rst_ni is low, both drive flags are 0 and both data outputs read 0. Reset clears both stores to zero.
- R2: When a direction's latch enable is 1 at a system clock edge, the store takes the source bus value at that edge. The value appears on the far side's output one cycle after the input was applied.
- R3: When the latch enable is 0 and the capture clock shows no low-to-high change between two consecutive system clock samples, the store keeps its value.
- R4: When the latch enable is 0 and the capture clock is sampled 1 after being sampled 0 on the previous edge, the store loads the source bus value.
- R5: A capture clock rise that is sampled while the latch enable is 1 is treated as pass-through. If the latch enable then drops while the capture clock stays 1, the last passed value is held and no second capture happens.
- R6: If the latch enable drops while the capture clock is 0, the last passed value is held until the next capture clock rise. That rise loads the source bus value present at that edge.
- R7: b_oe_o follows ab_oe_i, which is active high. a_oe_o is the inverse of ba_oe_ni, which is active low.
- R8: A data output reads 0 while its drive flag is 0. The drive enable has no effect on storage: a word loaded while the output is disabled appears once the enable returns.
- R9: The two directions are independent. Controls of one direction never change the other direction's store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 18 | Data arriving from side A |
| a_o | output | 18 | Data presented to side A (B-to-A store, gated) |
| a_oe_o | output | 1 | Side A drive flag |
| b_i | input | 18 | Data arriving from side B |
| b_o | output | 18 | Data presented to side B (A-to-B store, gated) |
| b_oe_o | output | 1 | Side B drive flag |
| ab_le_i | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_ck_i | input | 1 | A-to-B capture clock, rise loads |
| ab_oe_i | input | 1 | A-to-B drive enable, active high |
| ba_le_i | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_ck_i | input | 1 | B-to-A capture clock, rise loads |
| ba_oe_ni | input | 1 | B-to-A drive enable, active low |

## Verification
Directed sequences step each direction through pass-through, steady hold, and capture on a clock rise. They also cover the two sequences that separate a real edge detector from a level check: a clock rise that lands while the latch is open, and a latch that closes with the clock low. Enable toggles check that storage keeps working behind a disabled output. Random traffic with independent controls per direction exposes any coupling between the two paths and any confusion of enable polarity.

// File: rtl/bidir_bus_pkg.sv
package bidir_bus_pkg;
  typedef enum logic [1:0] {
    XM_HOLD = 2'd0,
    XM_PASS = 2'd1,
    XM_CAPT = 2'd2
  } xfer_mode_e;

  // transparency wins over a capture edge
  function automatic xfer_mode_e pick_mode(input logic le, input logic rise);
    if (le)        return XM_PASS;
    else if (rise) return XM_CAPT;
    else           return XM_HOLD;
  endfunction
endpackage

// File: rtl/ctl_edge.sv
module ctl_edge
  import bidir_bus_pkg::*;
(
  input  logic       clk_i,
  input  logic       le_i,
  input  logic       ck_i,
  output xfer_mode_e mode_o
);
  logic ck_q;

  // free-running sample, so edges are judged against the real last value
  always_ff @(posedge clk_i) begin
    ck_q <= ck_i;
  end

  logic rise;
  assign rise   = ck_i & ~ck_q;
  assign mode_o = pick_mode(le_i, rise);
endmodule

// File: rtl/dir_store.sv
module dir_store
  import bidir_bus_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  xfer_mode_e   mode_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else begin
      unique case (mode_i)
        XM_PASS, XM_CAPT: q_o <= din_i;
        default:          q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/out_gate.sv
module out_gate #(
  parameter int W = 18
) (
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] q_i,
  output logic [W-1:0] dout_o,
  output logic         en_o
);
  assign en_o   = en_i & rst_ni;
  assign dout_o = en_o ? q_i : '0;
endmodule

// File: rtl/bidir_bus_reg.sv
module bidir_bus_reg
  import bidir_bus_pkg::*;
#(
  parameter int W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o,
  input  logic         ab_le_i,
  input  logic         ab_ck_i,
  input  logic         ab_oe_i,
  input  logic         ba_le_i,
  input  logic         ba_ck_i,
  input  logic         ba_oe_ni
);
  localparam int NDIR = 2;  // 0: A->B, 1: B->A

  logic [W-1:0] din  [NDIR];
  logic [W-1:0] q    [NDIR];
  logic [W-1:0] dout [NDIR];
  logic         le   [NDIR];
  logic         ck   [NDIR];
  logic         en   [NDIR];
  logic         en_o [NDIR];
  xfer_mode_e   mode [NDIR];

  assign din[0] = a_i;
  assign din[1] = b_i;
  assign le[0]  = ab_le_i;
  assign le[1]  = ba_le_i;
  assign ck[0]  = ab_ck_i;
  assign ck[1]  = ba_ck_i;
  assign en[0]  = ab_oe_i;
  assign en[1]  = ~ba_oe_ni;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    ctl_edge u_ctl (
      .clk_i (clk_i),
      .le_i  (le[d]),
      .ck_i  (ck[d]),
      .mode_o(mode[d])
    );
    dir_store #(.W(W)) u_store (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .mode_i(mode[d]),
      .din_i (din[d]),
      .q_o   (q[d])
    );
    out_gate #(.W(W)) u_gate (
      .rst_ni(rst_ni),
      .en_i  (en[d]),
      .q_i   (q[d]),
      .dout_o(dout[d]),
      .en_o  (en_o[d])
    );
  end

  assign b_o    = dout[0];
  assign b_oe_o = en_o[0];
  assign a_o    = dout[1];
  assign a_oe_o = en_o[1];

  always_comb begin
    if (!rst_ni) begin
      AST_RST_QUIET: assert (!a_oe_o && !b_oe_o && a_o == '0 && b_o == '0); // R1
    end
  end

  AST_AB_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_le_i |=> q[0] == $past(a_i)); // R2
  AST_BA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_le_i |=> q[1] == $past(b_i)); // R2
  AST_AB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_i && !$rose(ab_ck_i)) |=> $stable(q[0])); // R3
  AST_BA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_le_i && !$rose(ba_ck_i)) |=> $stable(q[1])); // R3
  AST_AB_CAPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ab_le_i && $rose(ab_ck_i)) |=> q[0] == $past(a_i)); // R4
  AST_BA_CAPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_le_i && $rose(ba_ck_i)) |=> q[1] == $past(b_i)); // R4
  AST_B_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ab_oe_i |-> b_o == '0); // R8
  AST_A_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_oe_ni |-> a_o == '0); // R8
endmodule

// File: tb/sim_bidir_bus_reg.sv
`timescale 1ns/1ps
module sim_bidir_bus_reg;
  localparam int W = 18;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] a_o, b_o;
  logic a_oe_o, b_oe_o;
  logic ab_le = 0, ab_ck = 0, ab_oe = 0;
  logic ba_le = 0, ba_ck = 0, ba_oe_n = 1;

  bidir_bus_reg #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe_o),
    .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe_o),
    .ab_le_i(ab_le), .ab_ck_i(ab_ck), .ab_oe_i(ab_oe),
    .ba_le_i(ba_le), .ba_ck_i(ba_ck), .ba_oe_ni(ba_oe_n)
  );

  int total = 0, bad = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic pck_ab = 0, pck_ba = 0;
  string tag_ab = "", tag_ba = "";

  task automatic chk(string rq, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // next store value from R2..R5 rules
  function automatic string upd(input logic le, input logic ck, input logic pck,
                                input logic [W-1:0] din, inout logic [W-1:0] st);
    if (le) begin st = din; return "R2"; end
    if (ck && !pck) begin st = din; return "R4"; end
    return "R3";
  endfunction

  task automatic tick();
    string ta, tb;
    logic eb, ea;
    @(posedge clk);
    ta = "R3"; tb = "R3";
    if (rst_n) begin
      ta = upd(ab_le, ab_ck, pck_ab, a_i, m_ab);
      tb = upd(ba_le, ba_ck, pck_ba, b_i, m_ba);
    end else begin
      m_ab = '0; m_ba = '0;
    end
    pck_ab = ab_ck; pck_ba = ba_ck;
    #1;
    eb = ab_oe & rst_n;
    ea = ~ba_oe_n & rst_n;
    if (!eb) ta = "R8";
    if (!ea) tb = "R8";
    if (tag_ab != "") ta = tag_ab;
    if (tag_ba != "") tb = tag_ba;
    chk(ta, b_o, eb ? m_ab : '0);
    chk("R7", {{(W-1){1'b0}}, b_oe_o}, {{(W-1){1'b0}}, eb});
    chk(tb, a_o, ea ? m_ba : '0);
    chk("R7", {{(W-1){1'b0}}, a_oe_o}, {{(W-1){1'b0}}, ea});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    // R1: enables asserted but reset forces quiet outputs
    ab_oe = 1; ba_oe_n = 0; ab_le = 1; ba_le = 1; a_i = 18'h3ffff; b_i = 18'h15555;
    tag_ab = "R1"; tag_ba = "R1";
    repeat (3) tick();
    ab_le = 0; ba_le = 0;
    tick();
    @(negedge clk); rst_n = 1;
    tick(); // stores cleared, outputs enabled -> zeros
    tag_ab = ""; tag_ba = "";

    // R2: pass-through in both directions
    ab_le = 1; ba_le = 1; a_i = 18'h2aaaa; b_i = 18'h01234;
    tick();
    a_i = 18'h0f0f0; b_i = 18'h3c3c3;
    tick();
    // R3: closed, clock steady low
    ab_le = 0; ba_le = 0; a_i = 18'h11111; b_i = 18'h22222;
    tick(); tick();
    // R4: capture on rise, then hold while high
    ab_ck = 1; ba_ck = 1;
    tick();
    a_i = 18'h33333; b_i = 18'h04444;
    tick();
    // R5: rise during transparency, then close with clock high
    ab_ck = 0; ba_ck = 0; tick();
    ab_le = 1; ba_le = 1; ab_ck = 1; ba_ck = 1; a_i = 18'h2bead; b_i = 18'h1cafe;
    tag_ab = "R5"; tag_ba = "R5";
    tick();
    ab_le = 0; ba_le = 0; a_i = 18'h00bad; b_i = 18'h00dad;
    tick(); tick();
    // R6: close with clock low, then rise captures
    ab_ck = 0; ba_ck = 0; ab_le = 1; ba_le = 1; a_i = 18'h12345; b_i = 18'h23456;
    tag_ab = "R6"; tag_ba = "R6";
    tick();
    ab_le = 0; ba_le = 0; a_i = 18'h3abcd; b_i = 18'h0dcba;
    tick();
    ab_ck = 1; ba_ck = 1;
    tick();
    // R8: load while disabled, reappears on enable
    ab_oe = 0; ba_oe_n = 1; ab_ck = 0; ba_ck = 0; ab_le = 1; ba_le = 1;
    a_i = 18'h1f00f; b_i = 18'h20ff0;
    tag_ab = "R8"; tag_ba = "R8";
    tick();
    ab_le = 0; ba_le = 0; tick();
    ab_oe = 1; ba_oe_n = 0; tick();
    // R9: B->A captures while A->B holds
    tag_ab = "R9"; tag_ba = "R9";
    a_i = 18'h3ffff; b_i = 18'h00001; ba_ck = 1;
    tick();
    ab_ck = 1; ab_le = 0; ba_ck = 0; b_i = 18'h00777; a_i = 18'h10101;
    tick();
    tag_ab = ""; tag_ba = "";

    // random traffic, independent per direction
    for (int i = 0; i < 3000; i++) begin
      a_i     = W'($urandom);
      b_i     = W'($urandom);
      ab_le   = ($urandom % 4) == 0;
      ba_le   = ($urandom % 4) == 0;
      if (($urandom % 3) == 0) ab_ck = ~ab_ck;
      if (($urandom % 3) == 0) ba_ck = ~ba_ck;
      ab_oe   = ($urandom % 8) != 0;
      ba_oe_n = ($urandom % 8) == 0;
      tick();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule